// File: doc/BRIEF.md
# Mains-Locked Frame Sync Divider

This block derives the display refresh timing from the AC power line. Its input is a single digital bit that reflects the polarity of the line voltage: high while the line is positive, low while it is negative. The bit is brought into the clock domain and filtered against chatter. The block then turns each positive-to-negative crossing into a one-clock real-time clock pulse, once per mains cycle. Crossings in both directions are merged into an internal tick train running at twice the mains frequency.

A programmable divider passes every second, third or fourth tick of that train as the frame sync pulse. A 60 Hz line therefore gives frame rates of 60, 40 or 30 Hz, and a 50 Hz line gives 50, 33.3 or 25 Hz. The ratio comes from a 2-bit code that is captured together with a load strobe. One code value leaves the current setting and the count in progress untouched. A level-sensitive enable input suppresses frame sync while it is low. Both pulse outputs are active-low.

Top module: `mains_sync_divider`

## Requirements
- R1: After reset both `rtc_n_o` and `frame_sync_n_o` are high, the filtered polarity is taken as negative, and the divide ratio is 2.
- R2: `rtc_n_o` goes low for one clock for each accepted positive-to-negative polarity change, and never for a negative-to-positive change.
- R3: Accepted changes in both directions are each counted as one tick, so at divide-by-2 exactly one frame sync pulse is produced per mains cycle.
- R4: On a cycle with `cfg_load_i` high, `cfg_code_i` selects the ratio. `cfg_code_i[1]` is the first code bit and `cfg_code_i[0]` the second. The code 2'b10 selects divide-by-2, 2'b01 selects divide-by-3 and 2'b00 selects divide-by-4. The frame sync pulse is issued on the Nth tick.
- R5: A load with code 2'b11 has no effect: the ratio and the partial tick count are both kept.
- R6: A load with any other code restarts the tick count from zero, and a tick arriving in the same cycle is discarded.
- R7: While `sync_enable_i` is low, no frame sync pulse is produced and the tick count is held at zero; `rtc_n_o` is unaffected.
- R8: A polarity change is accepted only after the synchronized input has differed from the filtered value for FILTER_CYCLES consecutive clocks. Shorter glitches produce no pulse.
- R9: Every low pulse on `rtc_n_o` and `frame_sync_n_o` is exactly one clock wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_pol_i | input | 1 | Asynchronous line polarity, 1 = positive half-cycle |
| cfg_load_i | input | 1 | One-cycle strobe that captures `cfg_code_i` |
| cfg_code_i | input | 2 | Ratio code: 10 = /2, 01 = /3, 00 = /4, 11 = keep |
| sync_enable_i | input | 1 | Low suppresses frame sync generation |
| rtc_n_o | output | 1 | Active-low real-time clock pulse, one per mains cycle |
| frame_sync_n_o | output | 1 | Active-low frame sync pulse, every Nth crossing |

## Verification
The hardest situation to reach is a partly filled tick count meeting a ratio load. The keep code and the restart rule only show up when the count is neither zero nor at its terminal value. The stimulus first drives a single mains cycle under divide-by-4, which leaves two ticks pending. It then loads either the keep code or a new ratio and drives one more cycle. The frame sync pulses counted over the two cycles tell whether the pending count survived. Glitches just shorter and longer than the filter window, and an interval with the enable low followed by a count check, cover the filter and the hold-at-zero rule. A behavioural model in the bench compares both outputs on every clock.

// File: rtl/mains_sync_pkg.sv
package mains_sync_pkg;

   typedef enum logic [1:0] {
      DIV_BY2 = 2'd0,
      DIV_BY3 = 2'd1,
      DIV_BY4 = 2'd2
   } div_ratio_e;

   // Ratio codes, cfg_code[1] being the first bit of the pair
   localparam logic [1:0] CODE_KEEP = 2'b11;
   localparam logic [1:0] CODE_DIV2 = 2'b10;
   localparam logic [1:0] CODE_DIV3 = 2'b01;
   localparam logic [1:0] CODE_DIV4 = 2'b00;

   localparam int unsigned TICK_CNT_W = 2;

   function automatic div_ratio_e code_to_ratio(input logic [1:0] code);
      div_ratio_e r;
      case (code)
         CODE_DIV3: r = DIV_BY3;
         CODE_DIV4: r = DIV_BY4;
         default:   r = DIV_BY2;
      endcase
      return r;
   endfunction

   // Count value at which the pending tick completes a frame
   function automatic logic [TICK_CNT_W-1:0] ratio_last(input div_ratio_e r);
      logic [TICK_CNT_W-1:0] v;
      case (r)
         DIV_BY3: v = 2'd2;
         DIV_BY4: v = 2'd3;
         default: v = 2'd1;
      endcase
      return v;
   endfunction

endpackage

// File: rtl/mains_pol_filter.sv
module mains_pol_filter #(
   parameter int unsigned SYNC_STAGES   = 2,
   parameter int unsigned FILTER_CYCLES = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_i,
   output logic pol_o
);

   localparam int unsigned RUN_W = $clog2(FILTER_CYCLES + 1);
   localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(FILTER_CYCLES - 1);

   logic [SYNC_STAGES-1:0] meta_q;
   logic                   sync_bit;
   logic [RUN_W-1:0]       run_q;
   logic                   pol_q;

   generate
      for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) meta_q[0] <= 1'b0;
               else        meta_q[0] <= raw_i;
            end
         end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) meta_q[g] <= 1'b0;
               else        meta_q[g] <= meta_q[g-1];
            end
         end
      end
   endgenerate

   assign sync_bit = meta_q[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= '0;
         pol_q <= 1'b0;
      end else if (sync_bit == pol_q) begin
         run_q <= '0;
      end else if (run_q == RUN_LAST) begin
         pol_q <= sync_bit;
         run_q <= '0;
      end else begin
         run_q <= run_q + 1'b1;
      end
   end

   assign pol_o = pol_q;

endmodule

// File: rtl/mains_edge_detect.sv
module mains_edge_detect (
   input  logic clk,
   input  logic rst_n,
   input  logic pol_i,
   output logic fall_o,
   output logic rise_o
);

   logic pol_d;
   logic fall_q;
   logic rise_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pol_d  <= 1'b0;
         fall_q <= 1'b0;
         rise_q <= 1'b0;
      end else begin
         pol_d  <= pol_i;
         fall_q <= pol_d & ~pol_i;
         rise_q <= ~pol_d & pol_i;
      end
   end

   assign fall_o = fall_q;
   assign rise_o = rise_q;

endmodule

// File: rtl/mains_ratio_div.sv
module mains_ratio_div
   import mains_sync_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_i,
   input  logic       load_i,
   input  logic [1:0] code_i,
   input  logic       enable_i,
   output logic       sync_o
);

   div_ratio_e                ratio_q;
   logic [TICK_CNT_W-1:0]     cnt_q;
   logic                      sync_q;
   logic                      take_code;
   logic                      at_last;

   assign take_code = load_i && (code_i != CODE_KEEP);
   assign at_last   = (cnt_q == ratio_last(ratio_q));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ratio_q <= DIV_BY2;
         cnt_q   <= '0;
         sync_q  <= 1'b0;
      end else if (take_code) begin
         ratio_q <= code_to_ratio(code_i);
         cnt_q   <= '0;
         sync_q  <= 1'b0;
      end else if (!enable_i) begin
         cnt_q   <= '0;
         sync_q  <= 1'b0;
      end else if (tick_i) begin
         cnt_q   <= at_last ? '0 : cnt_q + 1'b1;
         sync_q  <= at_last;
      end else begin
         sync_q  <= 1'b0;
      end
   end

   assign sync_o = sync_q;

endmodule

// File: rtl/mains_sync_divider.sv
module mains_sync_divider #(
   parameter int unsigned SYNC_STAGES   = 2,
   parameter int unsigned FILTER_CYCLES = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       line_pol_i,
   input  logic       cfg_load_i,
   input  logic [1:0] cfg_code_i,
   input  logic       sync_enable_i,
   output logic       rtc_n_o,
   output logic       frame_sync_n_o
);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (FILTER_CYCLES < 2) begin : g_bad_filter
         $error("FILTER_CYCLES must be at least 2");
      end
   endgenerate

   logic filt_pol;
   logic fall_p;
   logic rise_p;
   logic comb_tick;
   logic sync_p;

   mains_pol_filter #(
      .SYNC_STAGES   (SYNC_STAGES),
      .FILTER_CYCLES (FILTER_CYCLES)
   ) u_filter (
      .clk   (clk),
      .rst_n (rst_n),
      .raw_i (line_pol_i),
      .pol_o (filt_pol)
   );

   mains_edge_detect u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .pol_i  (filt_pol),
      .fall_o (fall_p),
      .rise_o (rise_p)
   );

   assign comb_tick = fall_p | rise_p;

   mains_ratio_div u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_i   (comb_tick),
      .load_i   (cfg_load_i),
      .code_i   (cfg_code_i),
      .enable_i (sync_enable_i),
      .sync_o   (sync_p)
   );

   assign rtc_n_o        = ~fall_p;
   assign frame_sync_n_o = ~sync_p;

endmodule

// File: rtl/mains_sync_chk.sv
module mains_sync_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cfg_load_i,
   input logic [1:0] cfg_code_i,
   input logic       sync_enable_i,
   input logic       rtc_n_o,
   input logic       frame_sync_n_o,
   input logic       filt_pol,
   input logic       comb_tick
);

   assert_rtc_width_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !rtc_n_o |=> rtc_n_o);

   assert_sync_width_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_sync_n_o |=> frame_sync_n_o);

   // R2: an rtc pulse only follows a change to negative polarity
   assert_rtc_negative_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !rtc_n_o |-> !filt_pol);

   assert_sync_needs_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_sync_n_o |-> $past(comb_tick));

   assert_load_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_load_i && cfg_code_i != 2'b11) |=> frame_sync_n_o);

   assert_inhibit_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !sync_enable_i |=> frame_sync_n_o);

endmodule

bind mains_sync_divider mains_sync_chk u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .cfg_load_i     (cfg_load_i),
   .cfg_code_i     (cfg_code_i),
   .sync_enable_i  (sync_enable_i),
   .rtc_n_o        (rtc_n_o),
   .frame_sync_n_o (frame_sync_n_o),
   .filt_pol       (filt_pol),
   .comb_tick      (comb_tick)
);

// File: tb/mains_sync_divider_tb.sv
`timescale 1ns/1ps
module mains_sync_divider_tb;

   localparam int STAGES = 2;
   localparam int FILT   = 8;
   localparam int HALF   = 30;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       line_pol_i = 1'b0;
   logic       cfg_load_i = 1'b0;
   logic [1:0] cfg_code_i = 2'b11;
   logic       sync_enable_i = 1'b1;
   logic       rtc_n_o;
   logic       frame_sync_n_o;

   int total = 0;
   int bad = 0;
   bit done = 0;

   always #2 clk = ~clk;

   mains_sync_divider u_dut (
      .clk            (clk),
      .rst_n          (rst_n),
      .line_pol_i     (line_pol_i),
      .cfg_load_i     (cfg_load_i),
      .cfg_code_i     (cfg_code_i),
      .sync_enable_i  (sync_enable_i),
      .rtc_n_o        (rtc_n_o),
      .frame_sync_n_o (frame_sync_n_o)
   );

   // ---------------- behavioural reference model ----------------
   bit q[$];
   bit m_s, m_f, m_fd, m_fall, m_rise, m_sync;
   int m_run, m_div, m_cnt;

   task automatic model_reset();
      q.delete();
      for (int i = 0; i < STAGES - 1; i++) q.push_back(1'b0);
      m_s = 0; m_f = 0; m_fd = 0; m_fall = 0; m_rise = 0; m_sync = 0;
      m_run = 0; m_div = 2; m_cnt = 0;
   endtask

   initial model_reset();

   always @(posedge clk) begin
      if (!rst_n) begin
         model_reset();
      end else begin
         // divider stage uses the tick seen before this edge
         if (cfg_load_i && cfg_code_i != 2'b11) begin
            m_div  = (cfg_code_i == 2'b10) ? 2 : (cfg_code_i == 2'b01) ? 3 : 4;
            m_cnt  = 0;
            m_sync = 0;
         end else if (!sync_enable_i) begin
            m_cnt  = 0;
            m_sync = 0;
         end else if (m_fall || m_rise) begin
            m_cnt  = m_cnt + 1;
            m_sync = (m_cnt == m_div);
            if (m_sync) m_cnt = 0;
         end else begin
            m_sync = 0;
         end
         m_fall = m_fd && !m_f;
         m_rise = !m_fd && m_f;
         m_fd   = m_f;
         if (m_s != m_f) begin
            m_run++;
            if (m_run == FILT) begin
               m_f   = m_s;
               m_run = 0;
            end
         end else begin
            m_run = 0;
         end
         q.push_back(line_pol_i);
         m_s = q.pop_front();
      end
   end

   // ---------------- per-clock comparison and pulse monitor ----------------
   int rtc_cnt = 0, sync_cnt = 0;
   int rtc_run = 0, sync_run = 0, rtc_max = 0, sync_max = 0;

   always @(negedge clk) begin
      if (rst_n && !done) begin
         total++;
         if (rtc_n_o !== !m_fall) begin
            bad++;
            $display("FAIL R2 rtc per-clock: actual=%0b expected=%0b at %0t", rtc_n_o, !m_fall, $time);
         end
         total++;
         if (frame_sync_n_o !== !m_sync) begin
            bad++;
            $display("FAIL R4 sync per-clock: actual=%0b expected=%0b at %0t", frame_sync_n_o, !m_sync, $time);
         end
         if (!rtc_n_o) begin rtc_cnt++; rtc_run++; end else rtc_run = 0;
         if (!frame_sync_n_o) begin sync_cnt++; sync_run++; end else sync_run = 0;
         if (rtc_run > rtc_max) rtc_max = rtc_run;
         if (sync_run > sync_max) sync_max = sync_run;
      end
   end

   // ---------------- helpers ----------------
   task automatic clocks(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic mains(input int cycles);
      for (int c = 0; c < cycles; c++) begin
         line_pol_i = 1'b1; clocks(HALF);
         line_pol_i = 1'b0; clocks(HALF);
      end
   endtask

   task automatic load(input logic [1:0] code);
      @(negedge clk);
      cfg_code_i = code; cfg_load_i = 1'b1;
      @(negedge clk);
      cfg_load_i = 1'b0; cfg_code_i = 2'b11;
   endtask

   task automatic clear_counts();
      rtc_cnt = 0; sync_cnt = 0;
   endtask

   task automatic check(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // ---------------- watchdog ----------------
   initial begin
      #(200000 * 4);
      if (!done) begin
         done = 1;
         total++; bad++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   // ---------------- stimulus ----------------
   initial begin
      clocks(5);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 rtc idle after reset", int'(rtc_n_o), 1);
      check("R1 sync idle after reset", int'(frame_sync_n_o), 1);

      // R1 default /2, R3 both crossings counted, R2 one rtc per cycle
      clear_counts(); mains(12); clocks(40);
      check("R1 R3 default divide-by-2 syncs", sync_cnt, 12);
      check("R2 rtc pulses per 12 cycles", rtc_cnt, 12);

      load(2'b01); clear_counts(); mains(12); clocks(40);
      check("R4 code 01 divide-by-3", sync_cnt, 8);
      load(2'b00); clear_counts(); mains(12); clocks(40);
      check("R4 code 00 divide-by-4", sync_cnt, 6);
      load(2'b10); clear_counts(); mains(12); clocks(40);
      check("R4 code 10 divide-by-2", sync_cnt, 12);

      // R5: keep code preserves ratio and partial count
      load(2'b00); clear_counts(); mains(1); clocks(40);
      load(2'b11); mains(1); clocks(40);
      check("R5 keep code retains count and ratio", sync_cnt, 1);

      // R6: new ratio restarts count (two ticks pending are dropped)
      clear_counts(); mains(1); clocks(40);
      load(2'b01); mains(1); clocks(40);
      check("R6 reload restarts tick count", sync_cnt, 0);

      // R7: inhibit suppresses sync, rtc runs, count held at zero
      mains(2); clocks(40);
      sync_enable_i = 1'b0;
      clear_counts(); mains(12); clocks(40);
      check("R7 no sync while disabled", sync_cnt, 0);
      check("R7 rtc unaffected while disabled", rtc_cnt, 12);
      sync_enable_i = 1'b1;
      clear_counts(); mains(3); clocks(40);
      check("R7 count restarts from zero after enable", sync_cnt, 2);

      // R8: glitch shorter than the filter is ignored
      clear_counts();
      line_pol_i = 1'b1; clocks(FILT - 2);
      line_pol_i = 1'b0; clocks(40);
      check("R8 short glitch gives no rtc", rtc_cnt, 0);
      check("R8 short glitch gives no sync", sync_cnt, 0);
      line_pol_i = 1'b1; clocks(FILT + 4);
      line_pol_i = 1'b0; clocks(40);
      check("R8 pulse past filter accepted", rtc_cnt, 1);

      check("R9 rtc pulse width", rtc_max, 1);
      check("R9 sync pulse width", sync_max, 1);

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule